// File: doc/BRIEF.md
# Command-Framed Serial Register Port

This block is the host-facing serial slave of a data converter. A host reaches eight internal byte-wide registers over a chip select, a serial clock, a data input, a data output with a pad enable, and an active-low data-ready line. No transfer begins on a select edge. Each one opens with a command byte, recognised by a leading zero bit. That byte says whether the next transfer reads or writes and which register it addresses. The data phase that follows is one byte long, or three bytes for the conversion result.

The level of the chip select picks the serial clock polarity. Holding select low gives a three-wire link that idles with the clock high and samples on rising edges. Holding it high selects the opposite polarity. The converter core is modelled by an 18-bit result bus, a channel tag and a one-cycle strobe. When a strobe arrives, the block latches the result and pulls the data-ready line low. It releases the line once the host has read the complete result. All serial inputs are brought into the system clock domain before use, so serial clock edges count as events rather than clocks.

Top module: `serial_reg_port`

## Requirements
- R1: After reset, the block waits for a command, intN is high and doutEn is low.
- R2: A command byte is sent MSB first. Bit 7 is a 0 start bit, bit 6 is the direction (1 = read) and bits 5..3 are the register select. Bits 2..0 are reserved. While the block waits for a command, sample edges with din high never start one.
- R3: After a write command to selects 1 to 6, the next byte is stored MSB first. A later read of the same select returns that byte. All these registers reset to 8'h00.
- R4: A read of select 0 returns the command byte that requested it. A write command to select 0 has no data phase.
- R5: A read of select 7 shifts out 24 bits MSB first: result[17:10], then result[9:2], then {result[1:0], zero padding, channel tag in the low bits}.
- R6: doutEn is high only during the data phase of a read. It is low during command bytes and write data.
- R7: din is ignored while a read shifts out, so no register changes. A write to select 7 is accepted but changes nothing.
- R8: With csN low, din is sampled on the rising edge of sclk and dout changes on the falling edge. With csN high, din is sampled on the falling edge and dout changes on the rising edge.
- R9: A convValid pulse latches the result and channel tag and drives intN low on the next clock.
- R10: intN returns high after the 24th bit of a result read. If a new result was latched after that read took its snapshot, including in the same clock as the final bit, intN stays low.
- R11: A result read takes a snapshot when its command completes. A result latched mid-read does not change the bytes being shifted, and the next result read returns the new result.
- R12: RUN_LEN consecutive sample edges with din high abort any transfer and return the block to waiting for a command. A result read aborted this way leaves intN low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select level; also picks the serial clock polarity |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host, held high when idle |
| dout | output | 1 | Serial data to the host, forced low when not enabled |
| doutEn | output | 1 | Pad drive enable for dout; high only while a read shifts out |
| intN | output | 1 | Active-low data ready |
| convValid | input | 1 | One-cycle strobe: a new conversion result is on convResult |
| convResult | input | 18 | Conversion result |
| convChan | input | CHAN_W | Channel tag of the result |

## Verification
Two events on the data-ready flag can fall in the same system clock. One is a result strobe setting it. The other is the completion of a result read clearing it. The bench provokes this by holding convValid high through the whole half-period that contains the final sample edge of a read, so the strobe covers the clear cycle whatever the synchroniser latency. It judges the outcome by intN staying low after the read, and by the next read returning the new value. A second test fires the strobe in the middle of a read. It checks that the bytes already being shifted keep the old snapshot.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int REG_CNT   = 8;
  localparam int SEL_W     = $clog2(REG_CNT);
  localparam int BYTE_W    = 8;
  localparam int RES_W     = 18;
  localparam int DATA_BITS = 3 * BYTE_W;
  localparam int CNT_W     = $clog2(DATA_BITS);

  localparam logic [SEL_W-1:0] SEL_CMD  = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_DATA = SEL_W'(REG_CNT - 1);

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic             wrShift;   // shift din into the write shifter
    logic             wrCommit;  // store the completed write byte
    logic             rdLoad;    // load the read shifter (snapshot on data)
    logic             rdShift;   // present the next output bit
    logic             rdDone;    // last bit of a result read sampled
    logic [SEL_W-1:0] sel;       // register currently addressed
  } strobe_t;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic din,
  output logic sampleEdge,
  output logic shiftEdge,
  output logic dinS
);
  logic [STAGES-1:0] sclkP, dinP, csP;
  logic sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkP    <= '1;
      dinP     <= '1;
      csP      <= '0;
      sclkPrev <= 1'b1;
    end else begin
      sclkP    <= {sclkP[STAGES-2:0], sclk};
      dinP     <= {dinP[STAGES-2:0], din};
      csP      <= {csP[STAGES-2:0], csN};
      sclkPrev <= sclkP[STAGES-1];
    end
  end

  logic rose, fell;
  assign rose = sclkP[STAGES-1] & ~sclkPrev;
  assign fell = ~sclkP[STAGES-1] & sclkPrev;

  // Select low: sample on rise, shift on fall. Select high: the reverse.
  assign sampleEdge = csP[STAGES-1] ? fell : rose;
  assign shiftEdge  = csP[STAGES-1] ? rose : fell;
  assign dinS       = dinP[STAGES-1];
endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import srp_pkg::*;
#(
  parameter int RUN_LEN = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleEdge,
  input  logic                shiftEdge,
  input  logic                dinS,
  output strobe_t             stb,
  output logic [BYTE_W-1:0]   cmdView,
  output logic                doutEn
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_WRITE, ST_READ} state_t;

  state_t            state;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-2:0] cmdSh;
  logic [BYTE_W-1:0] cmdByte;
  logic [RUN_W-1:0]  runCnt;

  logic [BYTE_W-1:0] newCmd;
  logic              ifReset, cmdDone, lastRdBit;
  logic [SEL_W-1:0]  curSel;

  assign newCmd    = {cmdSh, dinS};
  assign ifReset   = sampleEdge && dinS && (runCnt == RUN_W'(RUN_LEN - 1));
  assign cmdDone   = sampleEdge && !ifReset && state == ST_CMD &&
                     bitCnt == CNT_W'(BYTE_W - 1);
  assign curSel    = cmdDone ? newCmd[5:3] : cmdByte[5:3];
  assign lastRdBit = bitCnt == ((curSel == SEL_DATA) ? CNT_W'(DATA_BITS - 1)
                                                     : CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      cmdSh   <= '0;
      cmdByte <= '0;
      runCnt  <= '0;
    end else begin
      if (sampleEdge)
        runCnt <= (dinS && !ifReset) ? runCnt + RUN_W'(1) : '0;
      if (ifReset) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
      end else if (sampleEdge) begin
        unique case (state)
          ST_IDLE: if (!dinS) begin
            state  <= ST_CMD;
            bitCnt <= CNT_W'(1);
            cmdSh  <= '0;
          end
          ST_CMD: begin
            cmdSh  <= newCmd[BYTE_W-2:0];
            bitCnt <= bitCnt + CNT_W'(1);
            if (cmdDone) begin
              cmdByte <= newCmd;
              bitCnt  <= '0;
              if (newCmd[6])                state <= ST_READ;
              else if (newCmd[5:3] == SEL_CMD) state <= ST_IDLE;
              else                          state <= ST_WRITE;
            end
          end
          ST_WRITE: begin
            bitCnt <= bitCnt + CNT_W'(1);
            if (bitCnt == CNT_W'(BYTE_W - 1)) state <= ST_IDLE;
          end
          ST_READ: begin
            bitCnt <= bitCnt + CNT_W'(1);
            if (lastRdBit) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    stb          = '0;
    stb.sel      = curSel;
    stb.wrShift  = sampleEdge && !ifReset && state == ST_WRITE;
    stb.wrCommit = stb.wrShift && bitCnt == CNT_W'(BYTE_W - 1) &&
                   curSel != SEL_DATA;
    stb.rdLoad   = cmdDone && newCmd[6];
    stb.rdShift  = shiftEdge && state == ST_READ;
    stb.rdDone   = sampleEdge && !ifReset && state == ST_READ &&
                   curSel == SEL_DATA && lastRdBit;
  end

  assign cmdView = cmdDone ? newCmd : cmdByte;
  assign doutEn  = state == ST_READ;
endmodule

// File: rtl/srp_datapath.sv
module srp_datapath
  import srp_pkg::*;
#(
  parameter int CHAN_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] cmdView,
  input  logic              dinS,
  input  logic              convValid,
  input  logic [RES_W-1:0]  convResult,
  input  logic [CHAN_W-1:0] convChan,
  output logic              doutBit,
  output logic              intN
);
  localparam int PAD_W = BYTE_W - 2 - CHAN_W;

  logic [REG_CNT-1:0][BYTE_W-1:0] rdView;
  logic [BYTE_W-2:0]   wrSh;
  logic [DATA_BITS-1:0] rdSh, snap;
  logic [RES_W-1:0]    resHold;
  logic [CHAN_W-1:0]   chanHold;
  logic                newSinceSnap, intAct;

  assign rdView[0]        = cmdView;
  assign rdView[REG_CNT-1] = '0;

  for (genvar g = 1; g < REG_CNT - 1; g++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                       q <= '0;
      else if (stb.wrCommit && stb.sel == SEL_W'(g))   q <= {wrSh, dinS};
    end
    assign rdView[g] = q;
  end

  if (PAD_W > 0) begin : g_pad
    assign snap = {resHold, {PAD_W{1'b0}}, chanHold};
  end else begin : g_nopad
    assign snap = {resHold, chanHold};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSh         <= '0;
      rdSh         <= '0;
      doutBit      <= 1'b0;
      resHold      <= '0;
      chanHold     <= '0;
      newSinceSnap <= 1'b0;
      intAct       <= 1'b0;
    end else begin
      if (stb.wrShift) wrSh <= {wrSh[BYTE_W-3:0], dinS};
      if (stb.rdLoad)
        rdSh <= (stb.sel == SEL_DATA) ? snap
                                      : {rdView[stb.sel], {(DATA_BITS-BYTE_W){1'b0}}};
      else if (stb.rdShift)
        rdSh <= {rdSh[DATA_BITS-2:0], 1'b0};
      if (stb.rdShift) doutBit <= rdSh[DATA_BITS-1];
      if (convValid) begin
        resHold  <= convResult;
        chanHold <= convChan;
      end
      if (convValid) newSinceSnap <= 1'b1;
      else if (stb.rdLoad && stb.sel == SEL_DATA) newSinceSnap <= 1'b0;
      if (convValid)       intAct <= 1'b1;
      else if (stb.rdDone) intAct <= newSinceSnap;
    end
  end

  assign intN = ~intAct;
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
#(
  parameter int RUN_LEN     = 32,
  parameter int CHAN_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              doutEn,
  output logic              intN,
  input  logic              convValid,
  input  logic [RES_W-1:0]  convResult,
  input  logic [CHAN_W-1:0] convChan
);
  logic              sampleEdge, shiftEdge, dinS, doutBit;
  strobe_t           stb;
  logic [BYTE_W-1:0] cmdView;

  srp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .sampleEdge(sampleEdge), .shiftEdge(shiftEdge), .dinS(dinS)
  );

  srp_ctrl #(.RUN_LEN(RUN_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleEdge(sampleEdge), .shiftEdge(shiftEdge),
    .dinS(dinS), .stb(stb), .cmdView(cmdView), .doutEn(doutEn)
  );

  srp_datapath #(.CHAN_W(CHAN_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdView(cmdView), .dinS(dinS),
    .convValid(convValid), .convResult(convResult), .convChan(convChan),
    .doutBit(doutBit), .intN(intN)
  );

  assign dout = doutBit & doutEn;
endmodule

// File: rtl/srp_checker.sv
module srp_checker
  import srp_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    convValid,
  input logic    intN,
  input logic    doutEn,
  input logic    sampleEdge,
  input strobe_t stb
);
  // R9
  int_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    convValid |=> !intN);
  // R9
  int_fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> $past(convValid));
  // R10
  int_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intN) |-> ($past(stb.rdDone) && !$past(convValid)));
  // R6
  no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrShift |-> !doutEn);
  // R8
  read_start_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doutEn) |-> $past(sampleEdge));
  // R7
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrShift, stb.rdShift, stb.rdLoad, stb.rdDone}));
endmodule

bind serial_reg_port srp_checker u_chk (
  .clk(clk), .rstN(rstN), .convValid(convValid), .intN(intN),
  .doutEn(doutEn), .sampleEdge(sampleEdge), .stb(stb)
);

// File: tb/test_serial_reg_port.sv
`timescale 1ns/1ps
module test_serial_reg_port;
  localparam int RUN_LEN = 16;
  localparam int CHAN_W  = 2;
  localparam int HALF    = 8;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b0, sclk = 1'b1, din = 1'b1;
  logic convValid = 1'b0;
  logic [17:0] convResult = '0;
  logic [CHAN_W-1:0] convChan = '0;
  logic dout, doutEn, intN;

  int errors = 0, checks = 0;
  bit pulseNow = 0;
  logic enAny, enAll;

  always #10 clk = ~clk;

  serial_reg_port #(.RUN_LEN(RUN_LEN), .CHAN_W(CHAN_W)) i_serial_reg_port (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din), .dout(dout),
    .doutEn(doutEn), .intN(intN), .convValid(convValid),
    .convResult(convResult), .convChan(convChan)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One bit: leading edge presents data, trailing edge samples (CPHA=1).
  task automatic xferBit(input logic b, output logic got);
    sclk = csN ? 1'b1 : 1'b0;
    din  = b;
    waitClk(HALF);
    got   = dout;
    enAny = enAny | doutEn;
    enAll = enAll & doutEn;
    sclk  = csN ? 1'b0 : 1'b1;
    if (pulseNow) convValid = 1'b1;
    waitClk(HALF);
    convValid = 1'b0;
  endtask

  task automatic xferByte(input logic [7:0] tx, output logic [7:0] rx);
    enAny = 0; enAll = 1;
    for (int i = 7; i >= 0; i--) xferBit(tx[i], rx[i]);
  endtask

  task automatic writeReg(input logic [2:0] sel, input logic [7:0] val);
    logic [7:0] rx;
    xferByte({2'b00, sel, 3'b000}, rx);
    chk(!enAny, "R6 command byte drives", 32'(enAny), 0);
    if (sel != 3'd0) begin
      xferByte(val, rx);
      chk(!enAny, "R6 write data drives", 32'(enAny), 0);
    end
  endtask

  task automatic readReg(input logic [2:0] sel, input logic [7:0] dinPat, output logic [7:0] val);
    logic [7:0] rx;
    xferByte({2'b01, sel, 3'b101}, rx);
    xferByte(dinPat, val);
    chk(enAll, "R6 read phase enable", 32'(enAll), 1);
  endtask

  // Result read; pulse a new result at sample of bit index pulseAt (-1 none).
  task automatic readData(input int pulseAt, output logic [23:0] val);
    logic [7:0] rx;
    logic g;
    xferByte(8'h7D, rx);
    for (int i = 23; i >= 0; i--) begin
      pulseNow = (23 - i) == pulseAt;
      xferBit(i[0], g);
      val[i] = g;
    end
    pulseNow = 0;
  endtask

  task automatic newResult(input logic [17:0] r, input logic [CHAN_W-1:0] c);
    convResult = r; convChan = c;
    convValid = 1; waitClk(1); convValid = 0; waitClk(2);
  endtask

  function automatic logic [23:0] packRes(input logic [17:0] r, input logic [CHAN_W-1:0] c);
    return {r, {(6 - CHAN_W){1'b0}}, c};
  endfunction

  task automatic setPolarity(input logic highSel);
    sclk = highSel ? 1'b0 : 1'b1;
    waitClk(6);
    csN = highSel;
    waitClk(6);
  endtask

  logic [7:0]  rv;
  logic [23:0] dv;
  logic [7:0]  shadow [1:6];

  initial begin
    waitClk(5);
    rstN = 1;
    waitClk(3);
    // R1
    chk(intN === 1'b1, "R1 intN after reset", 32'(intN), 1);
    chk(doutEn === 1'b0, "R1 doutEn after reset", 32'(doutEn), 0);
    for (int s = 1; s <= 6; s++) begin
      readReg(3'(s), 8'hFF, rv);
      chk(rv == 8'h00, "R3 reset value", 32'(rv), 0);
      shadow[s] = 8'h00;
    end

    // R2: idle clocks with din high start nothing
    enAny = 0; enAll = 1;
    for (int i = 0; i < 12; i++) begin logic g; xferBit(1'b1, g); end
    chk(!enAny, "R2 idle ones start nothing", 32'(enAny), 0);

    // R3/R8 sweep in both polarities (R8: csN low three-wire, then high)
    for (int pol = 0; pol < 2; pol++) begin
      setPolarity(pol[0]);
      for (int v = 0; v < 4; v++) begin
        for (int s = 1; s <= 6; s++) begin
          logic [7:0] val = 8'(s * 37 + v * 91) ^ (v[0] ? 8'hFF : 8'h00);
          writeReg(3'(s), val);
          shadow[s] = val;
        end
        for (int s = 1; s <= 6; s++) begin
          readReg(3'(s), 8'h3C, rv);
          chk(rv == shadow[s], pol ? "R8 CPOL0 R3 readback" : "R8 CPOL1 R3 readback",
              32'(rv), 32'(shadow[s]));
        end
      end
    end
    setPolarity(1'b0);

    // R4: read select 0 returns requesting command; write to select 0 is command only
    readReg(3'd0, 8'hFF, rv);
    chk(rv == 8'h45, "R4 command readback", 32'(rv), 32'h45);
    writeReg(3'd0, 8'h00);
    readReg(3'd2, 8'hFF, rv);
    chk(rv == shadow[2], "R4 no data phase after select 0 write", 32'(rv), 32'(shadow[2]));

    // R7: din ignored during read
    readReg(3'd3, 8'h00, rv);
    readReg(3'd3, 8'h0F, rv);
    chk(rv == shadow[3], "R7 din ignored in read", 32'(rv), 32'(shadow[3]));

    // R5/R9/R10 result reads over several patterns
    for (int k = 0; k < 4; k++) begin
      logic [17:0] r = (k == 0) ? 18'h3FFFF : (k == 1) ? 18'h00000 :
                       (k == 2) ? 18'h2AAAA : 18'h15A3C;
      newResult(r, CHAN_W'(k));
      chk(intN === 1'b0, "R9 intN low after result", 32'(intN), 0);
      readData(-1, dv);
      chk(dv == packRes(r, CHAN_W'(k)), "R5 result bytes", 32'(dv), 32'(packRes(r, CHAN_W'(k))));
      chk(intN === 1'b1, "R10 intN released after read", 32'(intN), 1);
    end

    // R7: write to data register ignored
    newResult(18'h12345, 2'd1);
    writeReg(3'd7, 8'hAA);
    readData(-1, dv);
    chk(dv == packRes(18'h12345, 2'd1), "R7 data write ignored", 32'(dv), 32'(packRes(18'h12345, 2'd1)));

    // R11: result mid-read keeps snapshot
    newResult(18'h0F0F0, 2'd2);
    convResult = 18'h30303; convChan = 2'd3;
    readData(10, dv);
    chk(dv == packRes(18'h0F0F0, 2'd2), "R11 snapshot coherent", 32'(dv), 32'(packRes(18'h0F0F0, 2'd2)));
    chk(intN === 1'b0, "R10 new result keeps intN low", 32'(intN), 0);
    readData(-1, dv);
    chk(dv == packRes(18'h30303, 2'd3), "R11 next read new result", 32'(dv), 32'(packRes(18'h30303, 2'd3)));
    chk(intN === 1'b1, "R10 released after catching up", 32'(intN), 1);

    // R10: result strobe overlapping the final sample edge
    newResult(18'h11111, 2'd0);
    convResult = 18'h22222; convChan = 2'd1;
    readData(23, dv);
    chk(dv == packRes(18'h11111, 2'd0), "R10 coincident read bytes", 32'(dv), 32'(packRes(18'h11111, 2'd0)));
    chk(intN === 1'b0, "R10 set wins over clear", 32'(intN), 0);
    readData(-1, dv);
    chk(dv == packRes(18'h22222, 2'd1), "R10 coincident new value", 32'(dv), 32'(packRes(18'h22222, 2'd1)));

    // R12: interface reset aborts a result read
    newResult(18'h2C0DE, 2'd2);
    begin
      logic [7:0] rx;
      logic g;
      xferByte(8'h78, rx);
      for (int i = 0; i < 4; i++) xferBit(1'b0, g);
      for (int i = 0; i < RUN_LEN - 1; i++) xferBit(1'b1, g);
      chk(doutEn === 1'b1, "R12 read alive before run limit", 32'(doutEn), 1);
      xferBit(1'b1, g);
      chk(doutEn === 1'b0, "R12 read aborted at run limit", 32'(doutEn), 0);
      chk(intN === 1'b0, "R12 abort keeps intN low", 32'(intN), 0);
    end
    readData(-1, dv);
    chk(dv == packRes(18'h2C0DE, 2'd2), "R12 recovery read", 32'(dv), 32'(packRes(18'h2C0DE, 2'd2)));
    readReg(3'd5, 8'hFF, rv);
    chk(rv == shadow[5], "R12 registers kept", 32'(rv), 32'(shadow[5]));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule